// File: doc/BRIEF.md
# TDM Serial Diagnostic Loopback Selector

This block sits between one TDM channel's serial transmitter and receiver on the inside and the external line pins on the outside. A two-bit mode field chooses the routing. In normal operation the channel talks straight to the line. Automatic echo sends the line's received bits back out. Internal loopback feeds the channel's own transmit stream into its receiver and still drives the line. Isolated loopback does the same internally but keeps the line pins quiet.

A new mode value takes effect only on a clock edge where the frame sync strobe is high, so a frame that is already in progress is never cut in the middle. Once the registered mode changes, the routing responds combinationally in the same cycle. The echo path uses one register, so the echoed bit appears on the transmit pin one clock after it was sampled from the receive pin. Every diagnostic mode assumes that transmit and receive run from the same clock.

Top module: `tdm_diag_loop`

## Requirements
- R1: The active mode changes only at a rising clock edge where `frame_sync` is 1, and it then takes the value of `mode_req`. At every other edge the active mode keeps its value, whatever `mode_req` does.
- R2: When `rst_n` is 0 at a rising edge, the active mode returns to normal (code 00), whatever mode was active before.
- R3: In mode 00 (normal), `line_txd` equals `tx_data`, `line_req` equals `tx_req`, `rx_data` equals `line_rxd`, and `tx_grant` equals `line_grant`.
- R4: In mode 01 (echo), `line_txd` equals the value `line_rxd` held at the previous rising edge. `rx_data` equals `line_rxd`. `line_req` equals `tx_req`. `tx_data` never reaches the line.
- R5: In modes 01, 10 and 11, `tx_grant` is 1 and `line_grant` has no effect. In mode 00, `tx_grant` follows `line_grant`.
- R6: In mode 10 (internal loopback), `rx_data` equals `tx_data`, `line_txd` equals `tx_data`, and `line_req` equals `tx_req`.
- R7: In mode 11 (isolated loopback), `rx_data` equals `tx_data`, while `line_txd` is all ones and `line_req` is 1 (idle). This holds from the first cycle in which mode 11 is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared transmit/receive bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_sync | input | 1 | Frame boundary strobe; a new mode is loaded when it is high |
| mode_req | input | 2 | Requested mode: 00 normal, 01 echo, 10 internal loopback, 11 isolated loopback |
| tx_data | input | LANES | Serial data from the channel transmitter |
| tx_req | input | 1 | Line request from the channel transmitter |
| line_rxd | input | LANES | External receive data pin |
| line_grant | input | 1 | External grant pin |
| line_txd | output | LANES | External transmit data pin |
| line_req | output | 1 | External request pin |
| rx_data | output | LANES | Data delivered to the channel receiver |
| tx_grant | output | 1 | Grant presented to the channel transmitter |

## Verification
If the registered mode is wrong, the error shows on the pins in the cycle right after the faulty edge. The line pins, the receiver input and the grant each select a different source in each mode, so any wrong mode value produces a pin that disagrees with the expected one. A mode that loads while `frame_sync` is low shows up one cycle after that edge, as pins routed for the requested mode rather than the held one. A broken echo register shows up on `line_txd` one cycle after the received bit it should have repeated.

// File: rtl/tdm_diag_pkg.sv
// Shared definitions for the TDM diagnostic loopback selector.
// Assumes: mode codes are fixed by the control field encoding.
package tdm_diag_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL  = 2'b00,
        MODE_ECHO    = 2'b01,
        MODE_LOOP    = 2'b10,
        MODE_ISOLATE = 2'b11
    } diag_mode_e;

endpackage

// File: rtl/tdm_mode_latch.sv
// Holds the active diagnostic mode. Loads a new value only at a frame
// boundary so a frame in progress is never switched midway.
// Assumes: frame_sync is synchronous to clk; reset is synchronous, active low.
module tdm_mode_latch
    import tdm_diag_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_sync,
    input  logic [1:0] mode_req,
    output diag_mode_e mode_q
);

    // Capture the requested mode on frame sync, clear to normal on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_NORMAL;
        end else if (frame_sync) begin
            mode_q <= diag_mode_e'(mode_req);
        end
    end

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_sync |=> $stable(mode_q)); // R1

    AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> (mode_q == diag_mode_e'($past(mode_req)))); // R1

    AST_RESET_NORMAL: assert property (@(posedge clk)
        !rst_n |=> (mode_q == MODE_NORMAL)); // R2

endmodule

// File: rtl/tdm_echo_reg.sv
// Registers the external receive lanes on every clock so echo mode can
// resend each received bit one cycle later.
// Assumes: receive and transmit share clk in echo mode.
module tdm_echo_reg #(
    parameter int LANES = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] rxd_in,
    output logic [LANES-1:0] echo_q
);

    // One flop per lane; resets to the idle (high) line level.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                echo_q[g] <= 1'b1;
            end else begin
                echo_q[g] <= rxd_in[g];
            end
        end
    end

endmodule

// File: rtl/tdm_path_mux.sv
// Combinational routing between the channel and the line pins, chosen
// by the active mode. Mode 11 drives the line pins to the idle level.
// Assumes: the mode input is already frame-aligned.
module tdm_path_mux
    import tdm_diag_pkg::*;
#(
    parameter int LANES = 1
) (
    input  diag_mode_e       mode,
    input  logic [LANES-1:0] tx_data,
    input  logic             tx_req,
    input  logic [LANES-1:0] line_rxd,
    input  logic [LANES-1:0] echo_q,
    input  logic             line_grant,
    output logic [LANES-1:0] line_txd,
    output logic             line_req,
    output logic [LANES-1:0] rx_data,
    output logic             tx_grant
);

    localparam logic [LANES-1:0] IDLE_LINE = {LANES{1'b1}};

    // Select each output's source for the current mode.
    always_comb begin
        line_txd = tx_data;
        line_req = tx_req;
        rx_data  = line_rxd;
        tx_grant = 1'b1;
        unique case (mode)
            MODE_NORMAL: begin
                tx_grant = line_grant;
            end
            MODE_ECHO: begin
                line_txd = echo_q;
            end
            MODE_LOOP: begin
                rx_data = tx_data;
            end
            MODE_ISOLATE: begin
                rx_data  = tx_data;
                line_txd = IDLE_LINE;
                line_req = 1'b1;
            end
            default: begin
                tx_grant = line_grant;
            end
        endcase
    end

endmodule

// File: rtl/tdm_diag_loop.sv
// Top of the TDM diagnostic loopback selector: frame-aligned mode
// register, echo register and routing mux between channel and line.
// Assumes: transmit and receive share clk in all diagnostic modes.
module tdm_diag_loop
    import tdm_diag_pkg::*;
#(
    parameter int LANES = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_sync,
    input  logic [1:0]       mode_req,
    input  logic [LANES-1:0] tx_data,
    input  logic             tx_req,
    input  logic [LANES-1:0] line_rxd,
    input  logic             line_grant,
    output logic [LANES-1:0] line_txd,
    output logic             line_req,
    output logic [LANES-1:0] rx_data,
    output logic             tx_grant
);

    diag_mode_e       mode_q;
    logic [LANES-1:0] echo_q;

    tdm_mode_latch i_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_sync (frame_sync),
        .mode_req   (mode_req),
        .mode_q     (mode_q)
    );

    tdm_echo_reg #(.LANES(LANES)) i_echo (
        .clk    (clk),
        .rst_n  (rst_n),
        .rxd_in (line_rxd),
        .echo_q (echo_q)
    );

    tdm_path_mux #(.LANES(LANES)) i_mux (
        .mode       (mode_q),
        .tx_data    (tx_data),
        .tx_req     (tx_req),
        .line_rxd   (line_rxd),
        .echo_q     (echo_q),
        .line_grant (line_grant),
        .line_txd   (line_txd),
        .line_req   (line_req),
        .rx_data    (rx_data),
        .tx_grant   (tx_grant)
    );

    AST_ECHO_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_ECHO) |-> (line_txd == $past(line_rxd))); // R4

    AST_GRANT_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != MODE_NORMAL) |-> tx_grant); // R5

    AST_LOOP_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_LOOP) |-> (rx_data == tx_data && line_txd == tx_data)); // R6

    AST_ISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_ISOLATE) |-> (line_txd == {LANES{1'b1}} && line_req
                                       && rx_data == tx_data)); // R7

endmodule

// File: tb/test_tdm_diag_loop.sv
// Self-checking bench for tdm_diag_loop: vector table, then directed cases.
module test_tdm_diag_loop;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       frame_sync;
    logic [1:0] mode_req;
    logic [0:0] tx_data;
    logic       tx_req;
    logic [0:0] line_rxd;
    logic       line_grant;
    logic [0:0] line_txd;
    logic       line_req;
    logic [0:0] rx_data;
    logic       tx_grant;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    tdm_diag_loop #(.LANES(1)) i_tdm_diag_loop (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_sync (frame_sync),
        .mode_req   (mode_req),
        .tx_data    (tx_data),
        .tx_req     (tx_req),
        .line_rxd   (line_rxd),
        .line_grant (line_grant),
        .line_txd   (line_txd),
        .line_req   (line_req),
        .rx_data    (rx_data),
        .tx_grant   (tx_grant)
    );

    // Vector layout: [9:8] mode, [7] tx_data, [6] tx_req, [5] line_rxd,
    // [4] line_grant, [3] exp line_txd, [2] exp line_req, [1] exp rx_data, [0] exp tx_grant
    localparam int NVEC = 9;
    localparam logic [9:0] VEC [NVEC] = '{
        10'b00_1000_1000,   // R3 normal
        10'b00_0111_0111,   // R3 normal
        10'b01_1100_0101,   // R4 echo, R5 grant forced
        10'b01_0010_1011,   // R4 echo
        10'b10_1000_1011,   // R6 loop
        10'b10_0110_0101,   // R6 loop
        10'b11_0010_1101,   // R7 isolate
        10'b11_1100_1111,   // R7 isolate
        10'b00_0101_0101    // R3 back to normal
    };

    task automatic chk(input string req, input string what,
                       input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic string mode_tag(input logic [1:0] m);
        case (m)
            2'b00:   return "R3";
            2'b01:   return "R4";
            2'b10:   return "R6";
            default: return "R7";
        endcase
    endfunction

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; frame_sync = 1'b1; mode_req = 2'b11;
        tx_data = 1'b0; tx_req = 1'b0; line_rxd = 1'b1; line_grant = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1; frame_sync = 1'b0;
        #1;
        // R2: reset state is normal routing despite mode_req=11 during reset
        chk("R2", "line_txd", line_txd[0], 1'b0);
        chk("R2", "rx_data", rx_data[0], 1'b1);
        chk("R2", "tx_grant", tx_grant, 1'b0);

        // Table walk: each vector loads its mode at a frame sync edge
        for (int i = 0; i < NVEC; i++) begin
            mode_req   = VEC[i][9:8];
            tx_data[0] = VEC[i][7];
            tx_req     = VEC[i][6];
            line_rxd[0]= VEC[i][5];
            line_grant = VEC[i][4];
            frame_sync = 1'b1;
            tick();
            frame_sync = 1'b0;
            #1;
            chk(mode_tag(VEC[i][9:8]), "line_txd", line_txd[0], VEC[i][3]);
            chk(mode_tag(VEC[i][9:8]), "line_req", line_req,    VEC[i][2]);
            chk(mode_tag(VEC[i][9:8]), "rx_data",  rx_data[0],  VEC[i][1]);
            chk("R5", "tx_grant", tx_grant, VEC[i][0]);
        end

        // R1: request without frame sync is ignored (still normal)
        mode_req = 2'b11; tx_data = 1'b0; tx_req = 1'b0; line_grant = 1'b0;
        repeat (2) tick();
        chk("R1", "line_txd held", line_txd[0], 1'b0);
        chk("R1", "line_req held", line_req, 1'b0);
        chk("R1", "tx_grant held", tx_grant, 1'b0);

        // R4: echo latency of one cycle over a bit pattern
        mode_req = 2'b01; line_rxd = 1'b1; frame_sync = 1'b1;
        tick();
        frame_sync = 1'b0; mode_req = 2'b00;
        for (int k = 0; k < 6; k++) begin
            logic prev;
            prev = line_rxd[0];
            line_rxd[0] = (k % 3 == 1);
            tx_data[0]  = ~prev;
            tick();
            chk("R4", "echo lag", line_txd[0], line_rxd[0]);
            line_rxd[0] = ~line_rxd[0];
            #0.5;
            chk("R4", "echo not combinational", line_txd[0], ~line_rxd[0]);
        end

        // R7: isolate takes effect in the first cycle after the sync edge
        mode_req = 2'b11; frame_sync = 1'b1; tx_data = 1'b0; tx_req = 1'b0;
        tick();
        frame_sync = 1'b0;
        chk("R7", "line_txd idle", line_txd[0], 1'b1);
        chk("R7", "line_req idle", line_req, 1'b1);

        // R2: reset from isolate returns to normal
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        #1;
        chk("R2", "line_txd after reset", line_txd[0], 1'b0);
        chk("R2", "line_req after reset", line_req, 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule